// File: doc/BRIEF.md
# Difference Code Sample Compressor

This block losslessly shrinks streams of slowly changing digitized samples that arrive interleaved from several channels. For every channel it stores a reference value and codes each new sample as its change from that reference. Small changes fold into a short symbol index: zero first, then the positive and negative step of each magnitude in turn. Each index gets a prefix code made of ones closed by a zero. A change too large for the short codes is sent as an escape marker followed by the full raw sample. The variable-length codes are packed most significant bit first into fixed-width output words.

Frames mark the unit of independent decoding. The first sample of every channel in a frame is always sent raw, and the last sample of a frame pads the bit store with zeros to a word boundary and flushes it. An optional noise band (a lossy mode) codes every change inside the band as zero and leaves the channel reference untouched. Intake uses a valid/ready handshake and output uses a valid/ready handshake. When the output stalls, the bit store fills and intake stops.

Top module: `dcsc_compressor`

## Requirements
- R1: Each channel keeps its own reference, which is the value a decoder would rebuild, and codes each sample against it. Samples from other channels in between do not disturb that reference.
- R2: A change d with |d| <= 3 (default UNARY_MAX = 7) is coded as symbol k followed by a zero, where k is sent as k ones. The symbol is k = 0 for d = 0, k = 2d-1 for d > 0 and k = -2d for d < 0. Examples: 0 -> "0", +1 -> "10", -1 -> "110", +3 -> "111110", -3 -> "1111110".
- R3: When the folded symbol reaches UNARY_MAX, the block sends UNARY_MAX ones followed by the 12-bit raw sample, most significant bit first, and the reference becomes the sample.
- R4: The block sends the escape code with the raw sample for the first sample of each channel after reset and for the first sample of each channel after a frame start. A sample carrying in_sof is itself the first of its frame.
- R5: With thr_en high, a change with |d| <= thr_level is coded as "0" and the channel reference stays unchanged. With thr_en low, thr_level has no effect on the output.
- R6: Code bits fill out_data from bit OUT_W-1 downward. Each word holds OUT_W consecutive bits of the code stream.
- R7: Accepting a sample with in_last pads any partial word with zeros and emits it. When the stream ends on a word boundary, no extra word is emitted. in_ready stays low from the cycle after that acceptance until the store is empty.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold and no bits are lost. in_ready drops while the store cannot take a longest code.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when valid and ready |
| in_sample | input | SAMPLE_W | Unsigned sample value |
| in_chan | input | CH_W | Channel index of the sample |
| in_sof | input | 1 | Sample opens a new frame |
| in_last | input | 1 | Sample closes the frame and triggers the flush |
| thr_en | input | 1 | Enables the noise band |
| thr_level | input | SAMPLE_W | Largest change magnitude coded as zero |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | OUT_W | Packed code word, first bit at the top |

## Verification
The assertions check four things on every cycle: that a stalled output word holds, that the bit store never exceeds its capacity, that intake closes after a closing sample, and that a padded word empties the store. They also check that frame-opening samples always take the escape length and that the noise band never acts while it is disabled. Only the bench scenarios can show that the code stream is right bit for bit. This covers the folding order of positive and negative changes, the per-channel references kept across interleaving, the reference left unchanged under suppression, and the exact word count when a frame ends on a word boundary.

// File: rtl/dcsc_pkg.sv
package dcsc_pkg;

   // How the current sample leaves the predictor
   typedef enum logic [1:0] {
      KIND_UNARY    = 2'd0,
      KIND_SUPPRESS = 2'd1,
      KIND_ESCAPE   = 2'd2
   } code_kind_e;

endpackage

// File: rtl/dcsc_predictor.sv
module dcsc_predictor
   import dcsc_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int CHANNELS  = 4,
   parameter int UNARY_MAX = 7,
   parameter int CH_W      = 2,
   parameter int SYM_W     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [CH_W-1:0]     chan,
   input  logic                sof,
   input  logic                thr_en,
   input  logic [SAMPLE_W-1:0] thr_level,
   output code_kind_e          kind,
   output logic [SYM_W-1:0]    sym
);
   localparam int SLOTS = 1 << CH_W;
   localparam int DW    = SAMPLE_W + 1;
   localparam int FW    = DW + 1;

   logic [SAMPLE_W-1:0] prev_arr [SLOTS];
   logic [SLOTS-1:0]    seen_vec;
   logic [SAMPLE_W-1:0] prev_sel;
   logic                first;
   logic signed [DW-1:0] diff;
   logic [DW-1:0]       mag;
   logic [FW-1:0]       fold;

   initial begin : elab_chk
      if (UNARY_MAX < 1) $error("UNARY_MAX must be at least 1");
      if ((1 << SYM_W) <= UNARY_MAX) $error("SYM_W too narrow");
   end

   always_comb begin
      prev_sel = prev_arr[chan];
      first    = sof || !seen_vec[chan];
      diff     = $signed({1'b0, sample}) - $signed({1'b0, prev_sel});
      mag      = diff[DW-1] ? $unsigned(-diff) : $unsigned(diff);
      if (diff == '0)
         fold = '0;
      else if (diff[DW-1])
         fold = {mag, 1'b0};
      else
         fold = {mag, 1'b0} - FW'(1);
      sym  = '0;
      kind = KIND_UNARY;
      if (first)
         kind = KIND_ESCAPE;
      else if (thr_en && (mag <= {1'b0, thr_level}))
         kind = KIND_SUPPRESS;
      else if (fold >= FW'(UNARY_MAX))
         kind = KIND_ESCAPE;
      else
         sym = fold[SYM_W-1:0];
   end

   // One reference register and one seen flag per live channel slot
   for (genvar c = 0; c < SLOTS; c++) begin : g_slot
      if (c < CHANNELS) begin : g_live
         logic [SAMPLE_W-1:0] prev_q;
         logic                seen_q;
         logic                hit;
         assign hit = (chan == CH_W'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= '0;
               seen_q <= 1'b0;
            end else if (take) begin
               if (sof)
                  seen_q <= hit;
               else if (hit)
                  seen_q <= 1'b1;
               if (hit && (kind != KIND_SUPPRESS))
                  prev_q <= sample;
            end
         end
         assign prev_arr[c] = prev_q;
         assign seen_vec[c] = seen_q;
      end else begin : g_idle
         assign prev_arr[c] = '0;
         assign seen_vec[c] = 1'b0;
      end
   end

endmodule

// File: rtl/dcsc_coder.sv
module dcsc_coder
   import dcsc_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int UNARY_MAX = 7,
   parameter int SYM_W     = 3,
   parameter int CODE_W    = 19,
   parameter int LEN_W     = 5
) (
   input  code_kind_e          kind,
   input  logic [SYM_W-1:0]    sym,
   input  logic [SAMPLE_W-1:0] raw,
   output logic [CODE_W-1:0]   code,
   output logic [LEN_W-1:0]    len
);
   localparam logic [UNARY_MAX-1:0] ESC_MARK = '1;

   logic [CODE_W-1:0] unary_bits;

   initial begin : elab_chk
      if (CODE_W != UNARY_MAX + SAMPLE_W) $error("CODE_W mismatch");
      if ((1 << LEN_W) <= CODE_W) $error("LEN_W too narrow");
   end

   // k ones followed by a closing zero, right aligned
   always_comb begin
      for (int i = 0; i < CODE_W; i++)
         unary_bits[i] = (i >= 1) && (i <= int'(sym));
   end

   always_comb begin
      case (kind)
         KIND_ESCAPE: begin
            code = {ESC_MARK, raw};
            len  = LEN_W'(CODE_W);
         end
         KIND_SUPPRESS: begin
            code = '0;
            len  = LEN_W'(1);
         end
         default: begin
            code = unary_bits;
            len  = LEN_W'(sym) + LEN_W'(1);
         end
      endcase
   end

endmodule

// File: rtl/dcsc_packer.sv
module dcsc_packer #(
   parameter int OUT_W  = 24,
   parameter int CODE_W = 19,
   parameter int LEN_W  = 5,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              last,
   input  logic [CODE_W-1:0] code,
   input  logic [LEN_W-1:0]  len,
   output logic              room,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_W-1:0]  out_data,
   output logic [CNT_W-1:0]  fill,
   output logic              flushing
);
   localparam int ACC_W = OUT_W + CODE_W;
   localparam logic [CNT_W-1:0] ACC_N  = CNT_W'(ACC_W);
   localparam logic [CNT_W-1:0] WORD_N = CNT_W'(OUT_W);
   localparam logic [CNT_W-1:0] ROOM_N = CNT_W'(ACC_W - CODE_W);

   logic [ACC_W-1:0] acc_q, acc_d, acc_pop, placed;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_pop, len_n, gap;
   logic             flush_q, flush_d, pop;

   initial begin : elab_chk
      if ((1 << CNT_W) <= ACC_W) $error("CNT_W too narrow");
      if (OUT_W < 1) $error("OUT_W must be positive");
   end

   assign out_valid = (cnt_q >= WORD_N) || (flush_q && (cnt_q != '0));
   assign out_data  = acc_q[ACC_W-1 -: OUT_W];
   assign room      = !flush_q && (cnt_q <= ROOM_N);
   assign pop       = out_valid && out_ready;
   assign fill      = cnt_q;
   assign flushing  = flush_q;

   always_comb begin
      len_n   = CNT_W'(len);
      acc_pop = pop ? (acc_q << OUT_W) : acc_q;
      cnt_pop = cnt_q;
      if (pop)
         cnt_pop = (cnt_q >= WORD_N) ? (cnt_q - WORD_N) : '0;
      gap     = ACC_N - cnt_pop - len_n;
      placed  = take ? (ACC_W'(code) << gap) : '0;
      acc_d   = acc_pop | placed;
      cnt_d   = take ? (cnt_pop + len_n) : cnt_pop;
      flush_d = flush_q;
      if (take && last)
         flush_d = 1'b1;
      else if (cnt_d == '0)
         flush_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cnt_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         acc_q   <= acc_d;
         cnt_q   <= cnt_d;
         flush_q <= flush_d;
      end
   end

endmodule

// File: rtl/dcsc_compressor.sv
module dcsc_compressor
   import dcsc_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int CHANNELS  = 4,
   parameter int UNARY_MAX = 7,
   parameter int OUT_W     = 24,
   localparam int CH_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic [CH_W-1:0]     in_chan,
   input  logic                in_sof,
   input  logic                in_last,
   input  logic                thr_en,
   input  logic [SAMPLE_W-1:0] thr_level,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [OUT_W-1:0]    out_data
);
   localparam int SYM_W  = $clog2(UNARY_MAX + 1);
   localparam int CODE_W = UNARY_MAX + SAMPLE_W;
   localparam int LEN_W  = $clog2(CODE_W + 1);
   localparam int CNT_W  = $clog2(OUT_W + CODE_W + 1);

   code_kind_e          code_kind;
   logic [SYM_W-1:0]    code_sym;
   logic [CODE_W-1:0]   code_bits;
   logic [LEN_W-1:0]    code_len;
   logic [CNT_W-1:0]    fill_cnt;
   logic                flush_pend;
   logic                take;

   initial begin : elab_chk
      if (SAMPLE_W < 2) $error("SAMPLE_W must be at least 2");
      if (CHANNELS < 1) $error("CHANNELS must be positive");
   end

   assign take = in_valid && in_ready;

   dcsc_predictor #(
      .SAMPLE_W(SAMPLE_W), .CHANNELS(CHANNELS), .UNARY_MAX(UNARY_MAX),
      .CH_W(CH_W), .SYM_W(SYM_W)
   ) u_pred (
      .clk(clk), .rst_n(rst_n), .take(take), .sample(in_sample),
      .chan(in_chan), .sof(in_sof), .thr_en(thr_en), .thr_level(thr_level),
      .kind(code_kind), .sym(code_sym)
   );

   dcsc_coder #(
      .SAMPLE_W(SAMPLE_W), .UNARY_MAX(UNARY_MAX), .SYM_W(SYM_W),
      .CODE_W(CODE_W), .LEN_W(LEN_W)
   ) u_code (
      .kind(code_kind), .sym(code_sym), .raw(in_sample),
      .code(code_bits), .len(code_len)
   );

   dcsc_packer #(
      .OUT_W(OUT_W), .CODE_W(CODE_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .take(take), .last(in_last),
      .code(code_bits), .len(code_len), .room(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .fill(fill_cnt), .flushing(flush_pend)
   );

endmodule

// File: rtl/dcsc_compressor_chk.sv
module dcsc_compressor_chk
   import dcsc_pkg::*;
#(
   parameter int OUT_W     = 24,
   parameter int CODE_W    = 19,
   parameter int UNARY_MAX = 7,
   parameter int LEN_W     = 5,
   parameter int CNT_W     = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_sof,
   input logic             in_last,
   input logic             thr_en,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_data,
   input logic [CNT_W-1:0] fill_cnt,
   input logic             flush_pend,
   input logic [LEN_W-1:0] code_len,
   input code_kind_e       code_kind
);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNT_W'(OUT_W + CODE_W));

   assert_flush_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_last |=> !in_ready);

   assert_pad_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pend && out_valid && out_ready && (fill_cnt < CNT_W'(OUT_W))
      |=> fill_cnt == '0);

   assert_first_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_sof |-> code_len == LEN_W'(CODE_W));

   assert_unary_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (code_kind == KIND_UNARY) |-> code_len <= LEN_W'(UNARY_MAX));

   assert_thr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !thr_en |-> code_kind != KIND_SUPPRESS);

endmodule

bind dcsc_compressor dcsc_compressor_chk #(
   .OUT_W(OUT_W), .CODE_W(CODE_W), .UNARY_MAX(UNARY_MAX),
   .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_sof(in_sof), .in_last(in_last), .thr_en(thr_en),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .fill_cnt(fill_cnt), .flush_pend(flush_pend), .code_len(code_len),
   .code_kind(code_kind)
);

// File: tb/dcsc_compressor_tb.sv
`timescale 1ns/1ps
module dcsc_compressor_tb;
   localparam int SW    = 12;
   localparam int NCH   = 4;
   localparam int UMAX  = 7;
   localparam int OW    = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [SW-1:0] in_sample = '0;
   logic [1:0] in_chan = '0;
   logic in_sof = 1'b0;
   logic in_last = 1'b0;
   logic thr_en = 1'b0;
   logic [SW-1:0] thr_level = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [OW-1:0] out_data;

   int checks = 0;
   int fails = 0;
   int ready_mode = 0;
   int cyc = 0;
   int popped = 0;
   int stalls = 0;
   string scen = "R9";

   bit bitq[$];
   logic [OW-1:0] wordq[$];
   int prev_m [NCH];
   bit seen_m [NCH];

   always #2.5 clk = ~clk;

   dcsc_compressor #(.SAMPLE_W(SW), .CHANNELS(NCH), .UNARY_MAX(UMAX), .OUT_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sample(in_sample), .in_chan(in_chan), .in_sof(in_sof), .in_last(in_last),
      .thr_en(thr_en), .thr_level(thr_level), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   task automatic put_bits(int unsigned v, int n);
      for (int i = n - 1; i >= 0; i--) bitq.push_back(v[i]);
      while (bitq.size() >= OW) begin
         logic [OW-1:0] w;
         for (int i = 0; i < OW; i++) w = {w[OW-2:0], bitq.pop_front()};
         wordq.push_back(w);
      end
   endtask

   task automatic model(int ch, int s, bit sof, bit last);
      int d, mag, k;
      if (sof) for (int c = 0; c < NCH; c++) seen_m[c] = 1'b0;
      d   = s - prev_m[ch];
      mag = (d < 0) ? -d : d;
      k   = (d == 0) ? 0 : ((d > 0) ? 2 * d - 1 : -2 * d);
      if (!seen_m[ch] || (!(thr_en && mag <= int'(thr_level)) && k >= UMAX)) begin
         put_bits((1 << UMAX) - 1, UMAX);
         put_bits(s, SW);
         prev_m[ch] = s;
      end else if (thr_en && mag <= int'(thr_level)) begin
         put_bits(0, 1);
      end else begin
         put_bits(((1 << k) - 1) << 1, k + 1);
         prev_m[ch] = s;
      end
      seen_m[ch] = 1'b1;
      if (last && bitq.size() > 0) put_bits(0, OW - bitq.size());
   endtask

   // ---------------- driver ----------------
   task automatic send(int ch, int s, bit sof, bit last);
      model(ch, s, sof, last);
      in_valid  = 1'b1;
      in_chan   = 2'(ch);
      in_sample = SW'(s);
      in_sof    = sof;
      in_last   = last;
      while (!in_ready) begin
         stalls++;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_last  = 1'b0;
      if (last) chk(in_ready == 1'b0, "R7", "in_ready after closing sample", int'(in_ready), 0);
   endtask

   task automatic drain();
      for (int i = 0; i < 4000; i++) begin
         if (wordq.size() == 0 && !out_valid) break;
         @(negedge clk);
      end
      chk(wordq.size() == 0, scen, "expected words left", wordq.size(), 0);
      chk(out_valid == 1'b0, scen, "out_valid after drain", int'(out_valid), 0);
   endtask

   // ---------------- output ready pattern ----------------
   initial forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 4) == 0);
   end

   // ---------------- monitor / scoreboard ----------------
   initial begin
      logic [OW-1:0] held;
      bit hold_pend = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (hold_pend) begin
               chk(out_valid && out_data == held, "R8", "held word",
                   int'(out_data), int'(held));
               hold_pend = 1'b0;
            end
            if (out_valid && out_ready) begin
               popped++;
               if (wordq.size() == 0)
                  chk(1'b0, {"R6/", scen}, "unexpected word", int'(out_data), -1);
               else begin
                  logic [OW-1:0] e;
                  e = wordq.pop_front();
                  chk(out_data == e, {"R6/", scen}, "word", int'(out_data), int'(e));
               end
            end else if (out_valid) begin
               held = out_data;
               hold_pend = 1'b1;
            end
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      int base, p0;
      int val [NCH];
      for (int c = 0; c < NCH; c++) begin prev_m[c] = 0; seen_m[c] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);

      // R2 / R4: folding order of small changes
      scen = "R2";
      send(0, 100, 1, 0);
      send(0, 101, 0, 0); send(0, 100, 0, 0); send(0, 102, 0, 0);
      send(0, 100, 0, 0); send(0, 103, 0, 0); send(0, 100, 0, 0);
      send(0, 100, 0, 1);
      drain();

      // R3: large changes take the escape path
      scen = "R3";
      send(1, 4095, 1, 0);
      send(1, 0, 0, 0); send(1, 4, 0, 0); send(1, 0, 0, 0); send(1, 3, 0, 1);
      drain();

      // R1: interleaved channels keep separate references
      scen = "R1";
      base = 0;
      for (int i = 0; i < 24; i++) begin
         int ch, s;
         ch = i % NCH;
         s  = 500 * (ch + 1) + ((i / NCH) % 3) - 1 + ch;
         send(ch, s, i == 0, i == 23);
      end
      drain();

      // R4: new frame forces raw again even for tiny change
      scen = "R4";
      send(2, 1999, 1, 0);
      send(2, 2000, 0, 0);
      send(3, 1501, 0, 0);
      send(2, 2001, 1, 1);
      drain();

      // R5: noise band, reference stays on suppression
      scen = "R5";
      thr_en = 1'b1; thr_level = 12'd2;
      send(0, 1000, 1, 0);
      send(0, 1002, 0, 0); send(0, 1003, 0, 0); send(0, 1004, 0, 0);
      send(0, 1001, 0, 0); send(0, 1010, 0, 1);
      drain();
      thr_en = 1'b0; thr_level = 12'd5;  // level ignored when disabled
      send(0, 50, 1, 0); send(0, 51, 0, 0); send(0, 49, 0, 1);
      drain();

      // R7: frame ending exactly on a word boundary (19 + 5 bits)
      scen = "R7";
      p0 = popped;
      send(1, 7, 1, 0);
      for (int i = 0; i < 5; i++) send(1, 7, 0, i == 4);
      drain();
      chk(popped - p0 == 1, "R7", "words for aligned frame", popped - p0, 1);

      // R8: heavy back-pressure with a long mixed stream
      scen = "R8";
      ready_mode = 1;
      stalls = 0;
      for (int c = 0; c < NCH; c++) val[c] = 300 * c + 40;
      for (int i = 0; i < 200; i++) begin
         int ch, dl;
         ch = i % NCH;
         dl = ((i * 7 + 3) % 11) - 5;
         if (i % 13 == 0) dl = 300;
         val[ch] = (val[ch] + dl) & 4095;
         send(ch, val[ch], i == 0, i == 199);
      end
      ready_mode = 0;
      drain();
      chk(stalls > 0, "R8", "intake stalls under back-pressure", stalls, 1);

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule